// File: doc/BRIEF.md
# Burst Receive Frame Lock and Packet Checker

This block sits behind the bit-slicer of a burst receiver. It takes the recovered serial stream one bit per strobe, waits for a run of alternating bits that marks the start of a burst, and then searches a bounded window for a 32-bit synchronisation pattern made of a configurable 16-bit word sent twice. The bit that completes the pattern fixes the byte framing for everything after it.

Once locked, it removes the whitening from each bit and walks a fixed header: a length byte, then an address byte, then the payload, then a 16-bit CRC. The header is screened in that order. The payload bytes are delivered one at a time, and one status pulse reports the outcome of the burst. After any outcome the block goes back to hunting for a fresh run of alternating bits.

Top module: `rx_pkt_sync_check`

## Requirements
- R1: The sync search opens only after 16 consecutive alternating valid bits. A shorter run followed by a correct sync pattern yields no output.
- R2: Sync needs an exact match of the last 32 valid bits with {cfg_sync_word, cfg_sync_word}, oldest bit first (oldest bit = cfg_sync_word[15]). The match may complete on any of the 64 valid bits that follow the bit that finished the alternating run. If no match occurs in those 64 bits, the search is abandoned and R1 applies again.
- R3: After any status pulse the block needs a new alternating run (R1) before it can lock again.
- R4: The first valid bit after the sync match is the MSB of the length byte. All bytes are MSB first, in the order length, address, payload, CRC.
- R5: Every bit from the length MSB through the last CRC bit is XORed with bit 0 of a 9-bit LFSR. The LFSR is loaded with 0x1FF at the sync match and steps once per such bit as next = {s[0]^s[5], s[8:1]}.
- R6: A de-whitened length of 0 or above cfg_max_len ends the burst with status code 1. No address check and no payload bytes follow. A length equal to cfg_max_len is accepted.
- R7: A de-whitened address that is neither cfg_local_addr nor 0xFF ends the burst with status code 2 and emits no payload bytes.
- R8: Each payload byte is presented on pay_byte with pay_vld high for exactly one cycle. This is the cycle after the edge that samples the byte's eighth bit.
- R9: The CRC uses polynomial 0x1021 with initial value 0xFFFF, over the de-whitened payload bits, MSB first. The received 16-bit CRC (MSB first) matching it gives code 0; a mismatch gives code 3.
- R10: stat_vld is high for one cycle, the cycle after the edge that samples the bit ending the burst (the last CRC bit, or a rejected header byte's last bit). It is never high together with pay_vld.
- R11: Cycles with bit_vld low change nothing.
- R12: While rst is high, pay_vld, pay_byte, stat_vld and stat_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe marking a recovered bit |
| bit_in | input | 1 | Recovered bit |
| cfg_sync_word | input | 16 | Sync word, sent twice on air |
| cfg_local_addr | input | 8 | Station address |
| cfg_max_len | input | 8 | Largest accepted payload length |
| pay_vld | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | De-whitened payload byte |
| stat_vld | output | 1 | Burst outcome strobe |
| stat_code | output | 2 | 0 accepted, 1 length, 2 address, 3 CRC |

## Verification
The stimulus includes alternating runs one bit too short and exactly long enough. This separates an early sync search from a correct one. Sync patterns are placed to complete on the 64th and on the 65th bit after the run, which exposes off-by-one window counters, and a foreign sync word shows whether the match is exact. Lengths of 0, the maximum and one above it, a foreign address, the broadcast address and a corrupted CRC each drive a different status code. Strobe gaps and a burst sent without a new run show whether idle cycles and re-arming are handled.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [1:0] {LK_HUNT, LK_SEEK, LK_HOLD} lock_st_t;
  typedef enum logic [2:0] {F_WAIT, F_LEN, F_ADR, F_PAY, F_CRC} fld_st_t;
  localparam logic [1:0] ST_OK  = 2'd0;
  localparam logic [1:0] ST_LEN = 2'd1;
  localparam logic [1:0] ST_ADR = 2'd2;
  localparam logic [1:0] ST_CRC = 2'd3;
endpackage

// File: rtl/rxp_frame_lock.sv
module rxp_frame_lock
  import rxp_pkg::*;
#(
  parameter int SYNC_W    = 16,
  parameter int PRE_BITS  = 16,
  parameter int SEEK_BITS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic              rearm,
  output logic              lock_hit
);
  localparam int PAT_W = 2 * SYNC_W;
  localparam int RUN_W = $clog2(PRE_BITS + 1);
  localparam int WIN_W = $clog2(SEEK_BITS);

  lock_st_t         st;
  logic [PAT_W-1:0] sh, nsh;
  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] win;

  assign nsh      = {sh[PAT_W-2:0], bit_in};
  assign lock_hit = bit_vld && (st == LK_SEEK) && (nsh == {sync_word, sync_word});

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= LK_HUNT;
      sh  <= '0;
      run <= '0;
      win <= '0;
    end else if (bit_vld) begin
      sh <= nsh;
      case (st)
        LK_HUNT: begin
          if (run == '0 || bit_in == sh[0]) begin
            run <= RUN_W'(1);
          end else if (run == RUN_W'(PRE_BITS - 1)) begin
            st  <= LK_SEEK;
            run <= '0;
            win <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end
        LK_SEEK: begin
          if (lock_hit) begin
            st <= LK_HOLD;
          end else if (win == WIN_W'(SEEK_BITS - 1)) begin
            st  <= LK_HUNT;
            run <= '0;
          end else begin
            win <= win + 1'b1;
          end
        end
        default: begin
          if (rearm) begin
            st  <= LK_HUNT;
            run <= '0;
          end
        end
      endcase
    end
  end

  // R3: a finished burst always sends the lock back to hunting
  a_r3_rearm_hunt: assert property (@(posedge clk) disable iff (rst)
    rearm |=> st == LK_HUNT);
  // R2: once locked, only a rearm releases the lock
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (st == LK_HOLD && !rearm) |=> st == LK_HOLD);
endmodule

// File: rtl/rxp_pn.sv
module rxp_pn #(
  parameter int          PN_W   = 9,
  parameter int          PN_TAP = 5,
  parameter logic [PN_W-1:0] PN_SEED = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic adv,
  output logic pn_bit
);
  logic [PN_W-1:0] s;

  assign pn_bit = s[0];

  always_ff @(posedge clk) begin
    if (rst || restart) s <= PN_SEED;
    else if (adv)       s <= {s[0] ^ s[PN_TAP], s[PN_W-1:1]};
  end
endmodule

// File: rtl/rxp_crc.sv
module rxp_crc #(
  parameter int             CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic fb;
  assign fb = crc[CRC_W-1] ^ din;

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= CRC_INIT;
    else if (en)      crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/rx_pkt_sync_check.sv
module rx_pkt_sync_check
  import rxp_pkg::*;
#(
  parameter int SYNC_W    = 16,
  parameter int PRE_BITS  = 16,
  parameter int SEEK_BITS = 64,
  parameter int BYTE_W    = 8,
  parameter int CRC_W     = 16,
  parameter int PN_W      = 9,
  parameter int PN_TAP    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic [SYNC_W-1:0] cfg_sync_word,
  input  logic [BYTE_W-1:0] cfg_local_addr,
  input  logic [BYTE_W-1:0] cfg_max_len,
  output logic              pay_vld,
  output logic [BYTE_W-1:0] pay_byte,
  output logic              stat_vld,
  output logic [1:0]        stat_code
);
  localparam int CNT_W = $clog2(CRC_W);

  fld_st_t           fst;
  logic [CNT_W-1:0]  cnt;
  logic [CRC_W-1:0]  acc, nword, crc_val;
  logic [BYTE_W-1:0] rem, nbyte;
  logic lock_hit, pn_bit, dbit, byte_end, word_end, len_bad, adr_bad, pkt_end;

  rxp_frame_lock #(.SYNC_W(SYNC_W), .PRE_BITS(PRE_BITS), .SEEK_BITS(SEEK_BITS)) u_lock (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .sync_word(cfg_sync_word), .rearm(pkt_end), .lock_hit(lock_hit));

  rxp_pn #(.PN_W(PN_W), .PN_TAP(PN_TAP)) u_pn (
    .clk(clk), .rst(rst), .restart(lock_hit),
    .adv(bit_vld && fst != F_WAIT), .pn_bit(pn_bit));

  rxp_crc #(.CRC_W(CRC_W)) u_crc (
    .clk(clk), .rst(rst), .clear(lock_hit),
    .en(bit_vld && fst == F_PAY), .din(dbit), .crc(crc_val));

  always_comb begin
    dbit     = bit_in ^ pn_bit;
    nword    = {acc[CRC_W-2:0], dbit};
    nbyte    = nword[BYTE_W-1:0];
    byte_end = (cnt == CNT_W'(BYTE_W - 1));
    word_end = (cnt == CNT_W'(CRC_W - 1));
    len_bad  = (nbyte == '0) || (nbyte > cfg_max_len);
    adr_bad  = (nbyte != cfg_local_addr) && (nbyte != '1);
    pkt_end  = bit_vld && ((fst == F_LEN && byte_end && len_bad) ||
                           (fst == F_ADR && byte_end && adr_bad) ||
                           (fst == F_CRC && word_end));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fst <= F_WAIT; cnt <= '0; acc <= '0; rem <= '0;
      pay_vld <= 1'b0; pay_byte <= '0; stat_vld <= 1'b0; stat_code <= ST_OK;
    end else begin
      pay_vld  <= 1'b0;
      stat_vld <= 1'b0;
      if (bit_vld) begin
        if (fst == F_WAIT) begin
          if (lock_hit) begin
            fst <= F_LEN; cnt <= '0; acc <= '0;
          end
        end else begin
          acc <= nword;
          cnt <= cnt + 1'b1;
          case (fst)
            F_LEN: if (byte_end) begin
              cnt <= '0;
              if (len_bad) begin
                stat_vld <= 1'b1; stat_code <= ST_LEN; fst <= F_WAIT;
              end else begin
                rem <= nbyte; fst <= F_ADR;
              end
            end
            F_ADR: if (byte_end) begin
              cnt <= '0;
              if (adr_bad) begin
                stat_vld <= 1'b1; stat_code <= ST_ADR; fst <= F_WAIT;
              end else begin
                fst <= F_PAY;
              end
            end
            F_PAY: if (byte_end) begin
              cnt      <= '0;
              pay_vld  <= 1'b1;
              pay_byte <= nbyte;
              rem      <= rem - 1'b1;
              if (rem == BYTE_W'(1)) fst <= F_CRC;
            end
            default: if (word_end) begin
              stat_vld  <= 1'b1;
              stat_code <= (nword == crc_val) ? ST_OK : ST_CRC;
              fst       <= F_WAIT;
            end
          endcase
        end
      end
    end
  end

  // R10: status is a single-cycle pulse
  a_r10_stat_pulse: assert property (@(posedge clk) disable iff (rst)
    stat_vld |=> !stat_vld);
  // R10: status never coincides with a payload byte
  a_r10_stat_excl: assert property (@(posedge clk) disable iff (rst)
    !(stat_vld && pay_vld));
  // R8: payload strobe lasts one cycle
  a_r8_byte_pulse: assert property (@(posedge clk) disable iff (rst)
    pay_vld |=> !pay_vld);
  // R4: the lock can only fire while no burst is being parsed
  a_r4_hit_idle: assert property (@(posedge clk) disable iff (rst)
    lock_hit |-> fst == F_WAIT);
endmodule

// File: tb/tb_rx_pkt_sync_check.sv
module tb_rx_pkt_sync_check;
  localparam bit [15:0] SW   = 16'h2DD4;
  localparam bit [7:0]  ADDR = 8'h5A;
  localparam int        MAXL = 8;

  logic clk = 1'b0, rst = 1'b1, bit_vld = 1'b0, bit_in = 1'b0;
  logic pay_vld, stat_vld;
  logic [7:0] pay_byte;
  logic [1:0] stat_code;

  rx_pkt_sync_check dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .cfg_sync_word(SW), .cfg_local_addr(ADDR), .cfg_max_len(8'(MAXL)),
    .pay_vld(pay_vld), .pay_byte(pay_byte), .stat_vld(stat_vld), .stat_code(stat_code));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, gap = 0, n_stat = 0, last_code = -1;
  int got_b[$];
  int exp_b[$];
  bit done = 1'b0;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int crc_step(int c, bit d);
    bit fb = c[15] ^ d;
    c = (c << 1) & 32'hFFFF;
    if (fb) c = c ^ 32'h1021;
    return c;
  endfunction

  function automatic int pn_step(int s);
    return (s >> 1) | (((s ^ (s >> 5)) & 1) << 8);
  endfunction

  // ---------------- behavioural reference, stepped every clock
  int  m_st, m_run, m_win, m_pn, m_crc, m_left, m_code, m_byte;
  bit  m_hist[$];
  bit  m_fld[$];
  bit  e_pv, e_sv, m_on = 1'b0;

  function automatic int fld_val();
    int v = 0;
    foreach (m_fld[i]) v = (v << 1) | int'(m_fld[i]);
    return v;
  endfunction

  function automatic bit pat_match();
    if (m_hist.size() != 32) return 1'b0;
    for (int k = 0; k < 32; k++)
      if (m_hist[k] != SW[15 - (k % 16)]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    bit b, prev, d;
    int v;
    m_on <= 1'b1;
    e_pv = 1'b0; e_sv = 1'b0;
    if (rst) begin
      m_st = 0; m_run = 0; m_win = 0; m_code = 0; m_byte = 0;
      m_hist = {}; m_fld = {};
    end else if (bit_vld) begin
      b = bit_in;
      prev = (m_hist.size() > 0) ? m_hist[$] : 1'b0;
      m_hist.push_back(b);
      if (m_hist.size() > 32) void'(m_hist.pop_front());
      if (m_st == 0) begin
        if (m_run == 0 || b == prev) m_run = 1; else m_run++;
        if (m_run == 16) begin m_st = 1; m_win = 0; m_run = 0; end
      end else if (m_st == 1) begin
        if (pat_match()) begin
          m_st = 2; m_pn = 9'h1FF; m_crc = 16'hFFFF; m_fld = {};
        end else begin
          m_win++;
          if (m_win == 64) begin m_st = 0; m_run = 0; end
        end
      end else begin
        d = b ^ m_pn[0];
        m_pn = pn_step(m_pn);
        m_fld.push_back(d);
        if (m_st == 4) m_crc = crc_step(m_crc, d);
        if (m_st == 5 && m_fld.size() == 16) begin
          e_sv = 1'b1; m_code = (fld_val() == m_crc) ? 0 : 3; m_st = 0; m_run = 0;
        end else if (m_st != 5 && m_fld.size() == 8) begin
          v = fld_val(); m_fld = {};
          if (m_st == 2) begin
            if (v == 0 || v > MAXL) begin e_sv = 1; m_code = 1; m_st = 0; m_run = 0; end
            else begin m_left = v; m_st = 3; end
          end else if (m_st == 3) begin
            if (v != ADDR && v != 255) begin e_sv = 1; m_code = 2; m_st = 0; m_run = 0; end
            else m_st = 4;
          end else begin
            e_pv = 1; m_byte = v; m_left--;
            if (m_left == 0) begin m_st = 5; m_fld = {}; end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_on && !done) begin
      chk("R8 pay_vld vs model", int'(pay_vld), int'(e_pv));
      if (e_pv) chk("R8 pay_byte vs model", int'(pay_byte), m_byte);
      chk("R10 stat_vld vs model", int'(stat_vld), int'(e_sv));
      if (e_sv) chk("R10 stat_code vs model", int'(stat_code), m_code);
    end
    if (pay_vld) got_b.push_back(int'(pay_byte));
    if (stat_vld) begin n_stat++; last_code = int'(stat_code); end
  end

  // ---------------- stimulus
  int g_pn, g_crc;

  task automatic send_bit(input bit b);
    bit_vld = 1'b1; bit_in = b;
    @(negedge clk);
    bit_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_wbyte(input int v, input bit is_pay);
    for (int i = 7; i >= 0; i--) begin
      bit d = v[i];
      if (is_pay) g_crc = crc_step(g_crc, d);
      send_bit(d ^ g_pn[0]);
      g_pn = pn_step(g_pn);
    end
  endtask

  task automatic send_pkt(input int npre, input bit [15:0] sw, input int filler,
                          input int len, input int addr, input bit bad_crc, input bit pay_out);
    bit s = sw[15];
    int c;
    got_b = {}; exp_b = {}; n_stat = 0; last_code = -1;
    repeat (2) send_bit(s ^ bit'((npre - 1) & 1));
    for (int k = 0; k < npre; k++) send_bit(s ^ bit'((npre - 1 - k) & 1));
    for (int k = 0; k < filler; k++) send_bit(1'b0);
    for (int r = 0; r < 2; r++)
      for (int i = 15; i >= 0; i--) send_bit(sw[i]);
    g_pn = 9'h1FF; g_crc = 16'hFFFF;
    send_wbyte(len, 1'b0);
    send_wbyte(addr, 1'b0);
    for (int i = 0; i < len; i++) begin
      int pb = (i * 37 + len * 11 + 5) & 255;
      if (pay_out) exp_b.push_back(pb);
      send_wbyte(pb, 1'b1);
    end
    c = g_crc ^ (bad_crc ? 1 : 0);
    send_wbyte((c >> 8) & 255, 1'b0);
    send_wbyte(c & 255, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_pkt(input int code, input string tag);
    chk({tag, " status count"}, n_stat, (code < 0) ? 0 : 1);
    if (code >= 0) chk({tag, " status code"}, last_code, code);
    chk({tag, " byte count"}, got_b.size(), exp_b.size());
    foreach (exp_b[i]) if (i < got_b.size()) chk({tag, " byte"}, got_b[i], exp_b[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 pay_vld in reset", int'(pay_vld), 0);
    chk("R12 pay_byte in reset", int'(pay_byte), 0);
    chk("R12 stat_vld in reset", int'(stat_vld), 0);
    chk("R12 stat_code in reset", int'(stat_code), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R4 R5 R9: plain burst to the local address
    send_pkt(16, SW, 0, 3, ADDR, 0, 1); expect_pkt(0, "R9 good burst");
    // R7 R11: broadcast with idle gaps between bits
    gap = 2;
    send_pkt(16, SW, 0, 1, 255, 0, 1); expect_pkt(0, "R11 broadcast with gaps");
    gap = 0;
    send_pkt(20, SW, 0, MAXL, ADDR, 0, 1); expect_pkt(0, "R6 length at maximum");
    send_pkt(16, SW, 0, MAXL + 1, ADDR, 0, 0); expect_pkt(1, "R6 length above maximum");
    send_pkt(16, SW, 0, 0, ADDR, 0, 0); expect_pkt(1, "R6 zero length");
    send_pkt(16, SW, 0, 2, 8'h33, 0, 0); expect_pkt(2, "R7 foreign address");
    send_pkt(16, SW, 0, 4, ADDR, 1, 1); expect_pkt(3, "R9 corrupted crc");
    send_pkt(15, SW, 0, 2, ADDR, 0, 0); expect_pkt(-1, "R1 short preamble");
    send_pkt(16, 16'h9A3C, 0, 2, ADDR, 0, 0); expect_pkt(-1, "R2 foreign sync word");
    send_pkt(16, SW, 32, 2, ADDR, 0, 1); expect_pkt(0, "R2 match on last window bit");
    send_pkt(16, SW, 33, 2, ADDR, 0, 0); expect_pkt(-1, "R2 match past window");
    send_pkt(16, SW, 0, 2, 255, 0, 1); expect_pkt(0, "R3 recovery burst");
    send_pkt(0, SW, 0, 2, ADDR, 0, 0); expect_pkt(-1, "R3 no preamble after burst");
    send_pkt(16, SW, 0, 5, ADDR, 0, 1); expect_pkt(0, "R3 relock after fresh preamble");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule